// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Pin Control

This block is one channel of a 16-bit timer. It holds a single general register and controls one shared I/O pin. It receives the count value from a separate counter and never advances it. A 4-bit mode code selects the channel's role. With code bit 3 clear, the register is a compare value. The pin can be driven to a chosen start level and then changed when the count reaches the register. With code bit 3 set, the register becomes a capture register. It latches the count on an edge of the pin or on a count tick from the neighbouring channel.

A write of the mode code also sets the pin level. In the output-compare codes, bit 2 gives the start level and bits 1:0 give the action at a match. In the capture codes, bits 2:0 pick the trigger. Buffer operation of the register suspends every capture and compare event. The neighbour trigger is also suspended while the neighbour runs from the undivided clock. Each capture or match raises a sticky event flag. Software clears the flag with a one-cycle clear strobe.

Top module: `tmr_cc_channel`

## Requirements
- R1: While reset is low, `pin_o`, `pin_oe_o` and `flag_o` are 0, `reg_o` is zero and the stored mode code is 0000.
- R2: A cycle with `mode_wr_i` high loads `mode_code_i`. On the next edge, `pin_o` takes the value of `mode_code_i` bit 2, for every code. No capture or compare event is generated in that write cycle.
- R3: `pin_oe_o` is high exactly when the stored code has bit 3 = 0 and bits 1:0 not equal to 00. It is therefore low for 0000, 0100 and every capture code 1xxx.
- R4: With bit 3 = 0, a compare match is a cycle in which `cnt_i` equals the register and did not equal it in the previous cycle. On the next edge the flag is set and the pin takes the action given by bits 1:0: 01 drives 0, 10 drives 1, 11 toggles, 00 leaves the pin alone.
- R5: The pin input passes through a two-flop synchroniser. An edge is detected between the second flop and one more delay flop. For a pin level first sampled at edge n, the register loads the value of `cnt_i` present at edge n+2. Code 1000 captures on rising edges, 1001 on falling edges, and 1010/1011 on both.
- R6: Codes 11xx load `cnt_i` into the register on the edge at which `nbr_tick_i` is high. This happens only while `nbr_undiv_i` is low; when it is high, no capture happens.
- R7: While `buf_en_i` is high, no capture and no compare event occurs. The register, the flag and the pin are left as they were.
- R8: The flag stays set until a cycle with `flag_clr_i` high. If an event and a clear fall in the same cycle, the event wins and the flag stays set.
- R9: `reg_wr_i` loads `reg_wdata_i` into the register. If a capture occurs in the same cycle, the captured count is stored instead.
- R10: In the output-compare codes the pin input has no effect. In the capture codes the count never changes `pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current counter value |
| pin_i | input | 1 | Pin level, asynchronous |
| nbr_tick_i | input | 1 | Neighbour channel count-up/count-down strobe |
| nbr_undiv_i | input | 1 | Neighbour counter is clocked by the undivided clock |
| mode_wr_i | input | 1 | Mode code write strobe |
| mode_code_i | input | 4 | Mode code to write |
| buf_en_i | input | 1 | Register is in buffer operation |
| reg_wr_i | input | 1 | General register write strobe |
| reg_wdata_i | input | CNT_W | General register write data |
| flag_clr_i | input | 1 | Event flag clear strobe |
| pin_o | output | 1 | Pin drive level |
| pin_oe_o | output | 1 | Pin output enable |
| reg_o | output | CNT_W | General register value |
| flag_o | output | 1 | Sticky capture/compare event flag |

## Verification
The bench builds the channel with CNT_W = 8 and SYNC_STAGES = 2. The 8-bit count wraps every 256 cycles, so the toggle code can be observed over several matches in a short run, and compare values can be put next to the wrap point. With two synchroniser stages the capture latency in R5 is exactly two edges. A model in the bench then predicts the captured count every cycle, for pin pulses as short as one cycle.

// File: rtl/tmr_cc_pkg.sv
`timescale 1ns/1ps
package tmr_cc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } cmp_act_e;

    typedef enum logic [1:0] {
        SRC_RISE = 2'b00,
        SRC_FALL = 2'b01,
        SRC_BOTH = 2'b10,
        SRC_NBR  = 2'b11
    } cap_src_e;

    typedef struct packed {
        logic     capture;
        logic     drive_en;
        logic     init_lvl;
        cmp_act_e act;
        cap_src_e src;
    } mode_t;

endpackage

// File: rtl/tmr_cc_decode.sv
`timescale 1ns/1ps
module tmr_cc_decode
    import tmr_cc_pkg::*;
(
    input  logic [3:0] code_i,
    output mode_t      mode_o
);

    always_comb begin
        mode_o.capture  = code_i[3];
        mode_o.init_lvl = code_i[2];
        mode_o.drive_en = !code_i[3] && (code_i[1:0] != 2'b00);
        mode_o.act      = code_i[3] ? ACT_NONE : cmp_act_e'(code_i[1:0]);
        if (code_i[2])      mode_o.src = SRC_NBR;
        else if (code_i[1]) mode_o.src = SRC_BOTH;
        else if (code_i[0]) mode_o.src = SRC_FALL;
        else                mode_o.src = SRC_RISE;
    end

endmodule

// File: rtl/tmr_cc_pin_sync.sv
`timescale 1ns/1ps
module tmr_cc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], pin_async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] && !chain_q[STAGES];
    assign fall_o = !chain_q[STAGES-1] && chain_q[STAGES];

    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_cc_channel.sv
`timescale 1ns/1ps
module tmr_cc_channel
    import tmr_cc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pin_i,
    input  logic             nbr_tick_i,
    input  logic             nbr_undiv_i,
    input  logic             mode_wr_i,
    input  logic [3:0]       mode_code_i,
    input  logic             buf_en_i,
    input  logic             reg_wr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    input  logic             flag_clr_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic [CNT_W-1:0] reg_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [3:0]       code;
        logic [CNT_W-1:0] gr;
        logic             pin;
        logic             flag;
        logic             eq;
    } state_t;

    state_t st_d, st_q;
    mode_t  mode;
    logic   rise, fall;
    logic   hit, blocked, trig, cmp_evt, cap_evt;

    tmr_cc_decode u_decode (
        .code_i (st_q.code),
        .mode_o (mode)
    );

    tmr_cc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async_i (pin_i),
        .rise_o      (rise),
        .fall_o      (fall)
    );

    always_comb begin
        st_d    = st_q;
        hit     = (cnt_i == st_q.gr);
        blocked = buf_en_i || mode_wr_i;
        st_d.eq = hit;

        case (mode.src)
            SRC_RISE: trig = rise;
            SRC_FALL: trig = fall;
            SRC_BOTH: trig = rise || fall;
            default:  trig = nbr_tick_i && !nbr_undiv_i;
        endcase

        cmp_evt = !mode.capture && hit && !st_q.eq && !blocked;
        cap_evt = mode.capture && trig && !blocked;

        if (mode_wr_i) st_d.code = mode_code_i;

        if (cap_evt)       st_d.gr = cnt_i;
        else if (reg_wr_i) st_d.gr = reg_wdata_i;

        if (mode_wr_i) begin
            st_d.pin = mode_code_i[2];
        end else if (cmp_evt) begin
            case (mode.act)
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_HIGH:   st_d.pin = 1'b1;
                ACT_TOGGLE: st_d.pin = !st_q.pin;
                default:    st_d.pin = st_q.pin;
            endcase
        end

        if (cmp_evt || cap_evt) st_d.flag = 1'b1;
        else if (flag_clr_i)    st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o    = st_q.pin;
    assign pin_oe_o = mode.drive_en;
    assign reg_o    = st_q.gr;
    assign flag_o   = st_q.flag;

    // R2
    pin_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> (pin_o == $past(mode_code_i[2])));

    // R3
    cap_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && mode_code_i[3]) |=> !pin_oe_o);

    // R7
    buf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en_i && !flag_o) |=> !flag_o);

    // R5
    cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> ((reg_o == $past(reg_o)) || flag_o));

    // R10
    out_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.capture && !reg_wr_i) |=> $stable(reg_o));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

endmodule

// File: tb/test_tmr_cc_channel.sv
`timescale 1ns/1ps
module test_tmr_cc_channel;

    localparam int W = 8;
    localparam int S = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '1;
    logic [W-1:0] cnt_set = '1;
    logic         run = 1'b0;
    logic         pin_in = 1'b0;
    logic         tick = 1'b0;
    logic         undiv = 1'b0;
    logic         mode_wr = 1'b0;
    logic [3:0]   code = 4'b0000;
    logic         buf_en = 1'b0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         clr = 1'b0;
    logic         pin_o, pin_oe, flag;
    logic [W-1:0] reg_v;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    tmr_cc_channel #(.CNT_W(W), .SYNC_STAGES(S)) i_tmr_cc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin_in),
        .nbr_tick_i(tick), .nbr_undiv_i(undiv), .mode_wr_i(mode_wr),
        .mode_code_i(code), .buf_en_i(buf_en), .reg_wr_i(reg_wr),
        .reg_wdata_i(wdata), .flag_clr_i(clr), .pin_o(pin_o),
        .pin_oe_o(pin_oe), .reg_o(reg_v), .flag_o(flag)
    );

    always #5ns clk = !clk;

    always @(negedge clk) cnt <= run ? cnt + 1'b1 : cnt_set;

    // Behavioural reference model
    logic [3:0]   m_code;
    logic [W-1:0] m_gr;
    bit           m_pin, m_flag, m_last_eq;
    bit           hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 4'b0000; m_gr = '0; m_pin = 0; m_flag = 0; m_last_eq = 0;
            hist.delete();
            for (int i = 0; i <= S; i++) hist.push_back(1'b0);
        end else begin
            bit nw, od, eq, blk, cmp, cap, trig;
            hist.push_back(pin_in);
            nw  = hist[hist.size()-1-S];
            od  = hist[hist.size()-2-S];
            if (hist.size() > 8) void'(hist.pop_front());
            eq  = (cnt == m_gr);
            blk = buf_en || mode_wr;
            cmp = !m_code[3] && eq && !m_last_eq && !blk;
            if (m_code[3:2] == 2'b11) trig = tick && !undiv;
            else if (m_code[1])       trig = (nw != od);
            else if (m_code[0])       trig = od && !nw;
            else                      trig = nw && !od;
            cap = m_code[3] && trig && !blk;
            if (mode_wr) m_pin = code[2];
            else if (cmp) begin
                if (m_code[1:0] == 2'b01)      m_pin = 0;
                else if (m_code[1:0] == 2'b10) m_pin = 1;
                else if (m_code[1:0] == 2'b11) m_pin = !m_pin;
            end
            if (cap)         m_gr = cnt;
            else if (reg_wr) m_gr = wdata;
            if (cmp || cap)  m_flag = 1;
            else if (clr)    m_flag = 0;
            if (mode_wr) m_code = code;
            m_last_eq = eq;
        end
    end

    function automatic bit exp_oe();
        return !m_code[3] && (m_code[1:0] != 2'b00);
    endfunction

    always @(negedge clk) begin
        if (chk_on && !done) begin
            checks++;
            if (pin_o !== m_pin) begin
                errors++;
                $display("FAIL %s pin_o actual %0b expected %0b", cur_req, pin_o, m_pin);
            end
            if (pin_oe !== exp_oe()) begin
                errors++;
                $display("FAIL %s pin_oe_o actual %0b expected %0b", cur_req, pin_oe, exp_oe());
            end
            if (reg_v !== m_gr) begin
                errors++;
                $display("FAIL %s reg_o actual %0h expected %0h", cur_req, reg_v, m_gr);
            end
            if (flag !== m_flag) begin
                errors++;
                $display("FAIL %s flag_o actual %0b expected %0b", cur_req, flag, m_flag);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] c);
        mode_wr <= 1'b1; code <= c;
        @(negedge clk);
        mode_wr <= 1'b0;
    endtask

    task automatic write_reg(input logic [W-1:0] v);
        reg_wr <= 1'b1; wdata <= v;
        @(negedge clk);
        reg_wr <= 1'b0;
    endtask

    task automatic clear_flag();
        clr <= 1'b1;
        @(negedge clk);
        clr <= 1'b0;
    endtask

    task automatic pin_pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pin_in <= 1'b1; idle(hi);
            pin_in <= 1'b0; idle(lo);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset values
        idle(3);
        checks++;
        if (pin_o !== 1'b0 || pin_oe !== 1'b0 || flag !== 1'b0 || reg_v !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b%0b%0b/%0h expected 000/0",
                     pin_o, pin_oe, flag, reg_v);
        end
        rst_n <= 1'b1;
        chk_on = 1'b1;
        idle(2);

        // R4: compare actions for each code, counter running over wraps
        cur_req = "R4";
        write_reg(8'h10);
        clear_flag();
        run <= 1'b1;
        for (int c = 0; c < 8; c++) begin
            set_mode(c[3:0]);
            if (c == 0 || c == 4) cur_req = "R3"; else cur_req = "R4";
            idle(300);
            clear_flag();
        end
        cur_req = "R4";
        set_mode(4'b0011);
        write_reg(8'hFF);
        idle(520);

        // R10: pin input ignored in compare modes
        cur_req = "R10";
        pin_pulses(6, 3, 5);

        // R2: mode write in the cycle of a fresh equality blocks the match
        cur_req = "R2";
        run <= 1'b0; cnt_set <= 8'h3F;
        write_reg(8'h40);
        clear_flag();
        idle(2);
        cnt_set <= 8'h40;
        set_mode(4'b0110);
        idle(4);
        for (int c = 0; c < 16; c++) begin
            set_mode(c[3:0]);
            idle(2);
        end

        // R7: buffer mode blocks compare
        cur_req = "R7";
        set_mode(4'b0011);
        clear_flag();
        buf_en <= 1'b1;
        run <= 1'b1;
        idle(300);
        buf_en <= 1'b0;
        idle(300);
        clear_flag();

        // R5: pin edge capture codes
        cur_req = "R5";
        set_mode(4'b1000);
        pin_pulses(5, 4, 7);
        pin_pulses(4, 1, 3);
        set_mode(4'b1001);
        pin_pulses(5, 2, 6);
        set_mode(4'b1010);
        pin_pulses(5, 3, 3);
        set_mode(4'b1011);
        pin_pulses(4, 1, 1);
        idle(6);
        // R10: capture mode, count never changes pin
        cur_req = "R10";
        idle(300);

        // R7: buffer mode blocks capture
        cur_req = "R7";
        clear_flag();
        buf_en <= 1'b1;
        pin_pulses(4, 3, 3);
        buf_en <= 1'b0;
        idle(4);

        // R6: neighbour tick capture, undivided clock blocks it
        cur_req = "R6";
        set_mode(4'b1100);
        clear_flag();
        for (int i = 0; i < 6; i++) begin
            tick <= 1'b1; idle(1);
            tick <= 1'b0; idle(4);
        end
        set_mode(4'b1111);
        clear_flag();
        undiv <= 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick <= 1'b1; idle(1);
            tick <= 1'b0; idle(3);
        end
        undiv <= 1'b0;
        tick <= 1'b1; idle(3); tick <= 1'b0;
        idle(2);

        // R9: capture beats register write in the same cycle
        cur_req = "R9";
        tick <= 1'b1; reg_wr <= 1'b1; wdata <= 8'hA5;
        idle(1);
        tick <= 1'b0; reg_wr <= 1'b0;
        idle(2);
        write_reg(8'h5A);
        idle(2);

        // R8: event and clear in the same cycle keep the flag set
        cur_req = "R8";
        clear_flag();
        idle(2);
        tick <= 1'b1; clr <= 1'b1;
        idle(1);
        tick <= 1'b0; clr <= 1'b0;
        idle(5);
        clear_flag();
        idle(5);

        finish_run();
    end

endmodule